// File: doc/BRIEF.md
# Serial PHY Management Frame Engine

This block runs one clause-22 style management transaction at a time on a two-wire PHY management bus. Software first sets a small control register. It holds a port-enable bit and a two-bit clock-divider select. Software then writes a 32-bit management word that contains the entire frame: start pattern, operation, PHY address, register address, turnaround code and 16 data bits. When the word is valid and the port is enabled, the engine sends a run of 32 preamble ones and then the word, most significant bit first. During a read it releases the data line over the turnaround and data bits. It samples the PHY's 16 data bits and writes them into the low half of the same management register, where software reads them once the idle flag returns high.

The management clock is the peripheral clock divided by 8, 16, 32 or 64. The select value is chosen so that the management clock stays within the PHY's limit at the present bus clock rate. The divider value and the operation type are taken when the transfer starts, so control writes made during a frame do not disturb it.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0, mdio_o is 1 and man_rdata is 0. The control register resets to port disabled with divider select 0.
- R2: A management write accepted while idle stores man_wdata, and man_rdata shows that value from the next cycle.
- R3: A transfer starts only when the port-enable bit is 1 and the written word is valid. A valid word has bits [31:30] = 01, bits [29:28] = 01 (write) or 10 (read), and bits [17:16] = 10. Any other word, or any word written while the port is disabled, is stored but leaves idle at 1.
- R4: idle goes low in the cycle after the write that starts a transfer. It stays low for exactly 64 mdc periods: 32 preamble bits followed by 32 frame bits.
- R5: Divider select 0, 1, 2 and 3 (ctl_div) gives an mdc period of 8, 16, 32 and 64 clocks. In each period mdc is low for the first half and high for the second half. mdc is 0 whenever idle is 1.
- R6: mdio_o carries 32 ones and then word bits 31 down to 0. Each bit is held for one mdc period and changes only in cycles where mdc is low. mdio_o is 1 while idle.
- R7: In a write frame mdio_oe is 1 for every bit. In a read frame mdio_oe drops at frame bit index 14 counted from the MSB (the two turnaround bits) and stays 0 to the end. mdio_oe is 0 while idle.
- R8: In a read, mdio_i is sampled on the clock edge where mdc rises during each of the 16 data bits, MSB first. When the frame ends, these bits replace man_rdata[15:0] and man_rdata[31:16] is unchanged.
- R9: A management write while idle is 0 is ignored. This includes a write on the final clock edge of a frame. The register keeps its contents, and no new frame starts.
- R10: The divider select and operation type are fixed when a transfer starts. A control write during a frame changes neither the timing nor the direction of that frame.
- R11: When a write frame ends, man_rdata still holds the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Management port enable value |
| ctl_div | input | 2 | Divider select value (0..3 → /8../64) |
| man_wr | input | 1 | Management word write strobe |
| man_wdata | input | 32 | Management word to write |
| man_rdata | output | 32 | Management register contents |
| idle | output | 1 | High when no transfer is in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
Frame completion and a new management write can fall in the same clock. In that cycle the completion commits the read data, and the write must be rejected because the engine still counts as busy. The bench times a write to the exact edge that ends a frame, using its own elapsed-cycle count since the start. It checks that the register keeps the captured data and that idle rises rather than staying low. A write made one cycle later must start a new frame. The reference model compares idle, mdc, mdio_o, mdio_oe and man_rdata on every clock, so a write that slipped through would show at once as a mismatch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int BASE_LOG2 = 3;                       // smallest divide is 2**3
  localparam int DIV_STEPS = 4;                       // /8, /16, /32, /64
  localparam int SEL_W     = $clog2(DIV_STEPS);
  localparam int CNT_W     = BASE_LOG2 + DIV_STEPS - 1;

  localparam int PRE_BITS  = 32;
  localparam int FRAME_W   = 32;
  localparam int DATA_W    = 16;
  localparam int TA_IDX    = 14;                      // first released frame bit (from MSB)
  localparam int TOTAL     = PRE_BITS + FRAME_W;
  localparam int BIT_W     = $clog2(TOTAL);

  typedef enum logic [1:0] {
    OP_RSVD_LO = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_RSVD_HI = 2'b11
  } mdio_op_e;

  function automatic logic frame_ok(input logic [FRAME_W-1:0] w);
    logic sof_ok, op_ok, code_ok;
    sof_ok  = (w[31:30] == 2'b01);
    op_ok   = (w[29:28] == OP_WRITE) || (w[29:28] == OP_READ);
    code_ok = (w[17:16] == 2'b10);
    return sof_ok && op_ok && code_ok;
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term, half_m1;
  logic             mdc_q, mdc_d;

  // terminal count per select step, computed rather than tabulated
  always_comb begin
    term = '0;
    for (int i = 0; i < DIV_STEPS; i++) begin
      if (sel == SEL_W'(i)) term = CNT_W'((1 << (BASE_LOG2 + i)) - 1);
    end
    half_m1 = term >> 1;
  end

  assign rise_evt = run && (cnt_q == half_m1);
  assign fall_evt = run && (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      if (fall_evt) cnt_d = '0;
      else          cnt_d = cnt_q + CNT_W'(1);
      if (rise_evt) mdc_d = 1'b1;
      if (fall_evt) mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [SEL_W-1:0]   div_in,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               mdio_i,
  output logic               busy,
  output logic [SEL_W-1:0]   div_sel,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic               done_rd,
  output logic [DATA_W-1:0]  cap_data
);

  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(TOTAL - 1);
  localparam int               REL_FROM  = PRE_BITS + TA_IDX;
  localparam int               DATA_FROM = TOTAL - DATA_W;

  logic               busy_q, busy_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               rd_q, rd_d;
  logic [SEL_W-1:0]   div_q, div_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic               out_q, out_d;
  logic               oe_q, oe_d;
  logic [BIT_W:0]     nxt_idx;

  // value on the line for a given position in preamble+frame
  function automatic logic line_bit(input int idx, input logic [FRAME_W-1:0] w);
    if (idx < PRE_BITS) return 1'b1;
    return w[FRAME_W - 1 - (idx - PRE_BITS)];
  endfunction

  assign nxt_idx = {1'b0, bit_q} + (BIT_W+1)'(1);
  assign done    = busy_q && fall_evt && (bit_q == LAST_BIT);
  assign done_rd = done && rd_q;

  always_comb begin
    busy_d  = busy_q;
    bit_d   = bit_q;
    frame_d = frame_q;
    rd_d    = rd_q;
    div_d   = div_q;
    cap_d   = cap_q;
    out_d   = out_q;
    oe_d    = oe_q;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      bit_d   = '0;
      frame_d = frame_in;
      rd_d    = (frame_in[29:28] == OP_READ);
      div_d   = div_in;
      out_d   = 1'b1;
      oe_d    = 1'b1;
    end else if (busy_q) begin
      if (rise_evt && (int'(bit_q) >= DATA_FROM)) begin
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          bit_d  = '0;
          out_d  = 1'b1;
          oe_d   = 1'b0;
        end else begin
          bit_d = nxt_idx[BIT_W-1:0];
          out_d = line_bit(int'(nxt_idx), frame_q);
          oe_d  = !(rd_q && (int'(nxt_idx) >= REL_FROM));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      div_q   <= '0;
      cap_q   <= '0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
      rd_q    <= rd_d;
      div_q   <= div_d;
      cap_q   <= cap_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign busy     = busy_q;
  assign div_sel  = div_q;
  assign mdio_o   = out_q;
  assign mdio_oe  = oe_q;
  assign cap_data = cap_q;

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_en,
  input  logic [SEL_W-1:0]   ctl_div,
  input  logic               man_wr,
  input  logic [FRAME_W-1:0] man_wdata,
  input  logic               busy,
  input  logic               done_rd,
  input  logic [DATA_W-1:0]  cap_data,
  output logic               start,
  output logic [SEL_W-1:0]   div_cfg,
  output logic [FRAME_W-1:0] man_rdata
);

  logic               en_q, en_d;
  logic [SEL_W-1:0]   div_q, div_d;
  logic [FRAME_W-1:0] man_q, man_d;
  logic               accept;

  assign accept = man_wr && !busy;
  assign start  = accept && en_q && frame_ok(man_wdata);

  always_comb begin
    en_d  = en_q;
    div_d = div_q;
    man_d = man_q;
    if (ctl_wr) begin
      en_d  = ctl_en;
      div_d = ctl_div;
    end
    if (accept) begin
      man_d = man_wdata;
    end else if (done_rd) begin
      man_d[DATA_W-1:0] = cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
      man_q <= '0;
    end else begin
      en_q  <= en_d;
      div_q <= div_d;
      man_q <= man_d;
    end
  end

  assign div_cfg   = div_q;
  assign man_rdata = man_q;

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_en,
  input  logic [1:0]  ctl_div,
  input  logic        man_wr,
  input  logic [31:0] man_wdata,
  output logic [31:0] man_rdata,
  output logic        idle,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  logic               rst_s1, srst_n;
  logic               start, busy, seq_done, done_rd;
  logic               rise_evt, fall_evt;
  logic [SEL_W-1:0]   div_cfg, div_run;
  logic [DATA_W-1:0]  cap_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      srst_n <= rst_s1;
    end
  end

  mdio_mgmt_regs u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .ctl_wr    (ctl_wr),
    .ctl_en    (ctl_en),
    .ctl_div   (ctl_div),
    .man_wr    (man_wr),
    .man_wdata (man_wdata),
    .busy      (busy),
    .done_rd   (done_rd),
    .cap_data  (cap_data),
    .start     (start),
    .div_cfg   (div_cfg),
    .man_rdata (man_rdata)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .frame_in (man_wdata),
    .div_in   (div_cfg),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .div_sel  (div_run),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (seq_done),
    .done_rd  (done_rd),
    .cap_data (cap_data)
  );

  mdio_clkdiv u_div (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (busy),
    .sel      (div_run),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign idle = !busy;

endmodule

// File: rtl/mdio_mgmt_engine_chk.sv
module mdio_mgmt_engine_chk (
  input logic        clk,
  input logic        srst_n,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        man_wr,
  input logic [31:0] man_rdata,
  input logic        seq_done
);

  p_mdc_quiet_r5: assert property (@(posedge clk) disable iff (!srst_n)
    idle |-> !mdc);

  p_oe_released_r7: assert property (@(posedge clk) disable iff (!srst_n)
    idle |-> !mdio_oe);

  p_data_moves_low_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(mdio_o) |-> !mdc);

  p_start_by_write_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(idle) |-> $past(man_wr));

  p_end_after_high_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(idle) |-> $past(mdc));

  p_busy_write_dropped_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (!idle && man_wr && !seq_done) |=> $stable(man_rdata));

endmodule

bind mdio_mgmt_engine mdio_mgmt_engine_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .idle      (idle),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .man_wr    (man_wr),
  .man_rdata (man_rdata),
  .seq_done  (seq_done)
);

// File: tb/mdio_mgmt_engine_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_bench;

  logic        clk;
  logic        rst_n;
  logic        ctl_wr, ctl_en;
  logic [1:0]  ctl_div;
  logic        man_wr;
  logic [31:0] man_wdata;
  logic [31:0] man_rdata;
  logic        idle, mdc, mdio_i, mdio_o, mdio_oe;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  mdio_mgmt_engine u_mdio_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_div(ctl_div),
    .man_wr(man_wr), .man_wdata(man_wdata), .man_rdata(man_rdata), .idle(idle),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int          k = 0;           // posedges seen
  int          rcnt = 0;
  bit          m_busy = 0, m_rd = 0, m_en = 0;
  int          m_ts = 0, m_N = 8;
  logic [1:0]  m_div = 0;
  logic [31:0] m_word = 0, m_reg = 0;
  logic [15:0] phy_val = 16'h0;

  function automatic bit valid_word(input logic [31:0] w);
    return (w[31:30] == 2'b01) && (w[29:28] == 2'b01 || w[29:28] == 2'b10) && (w[17:16] == 2'b10);
  endfunction

  always @(posedge clk) begin
    bit b4;
    k = k + 1;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt = rcnt + 1;
      m_busy = 0; m_en = 0; m_div = 0; m_reg = 0;
    end else begin
      b4 = m_busy;
      if (m_busy && (k - m_ts) == 64 * m_N) begin
        m_busy = 0;
        if (m_rd) m_reg[15:0] = phy_val;
      end
      if (man_wr && !b4) begin
        m_reg = man_wdata;
        if (m_en && valid_word(man_wdata)) begin
          m_busy = 1; m_ts = k; m_N = 8 << m_div; m_word = man_wdata;
          m_rd = (man_wdata[29:28] == 2'b10);
        end
      end
      if (ctl_wr) begin m_en = ctl_en; m_div = ctl_div; end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, then drive the PHY side of the data line
  always @(negedge clk) begin
    int e, b, ph;
    logic xm, xo, xe;
    if (m_busy) begin
      e = k - m_ts; ph = e % m_N; b = e / m_N;
      xm = (ph >= m_N / 2);
      xo = (b < 32) ? 1'b1 : m_word[63 - b];
      xe = !(m_rd && b >= 46);
    end else begin
      b = 0; xm = 0; xo = 1; xe = 0;
    end
    chk("R4", "idle",     {31'b0, idle},   {31'b0, !m_busy});
    chk("R5", "mdc",      {31'b0, mdc},    {31'b0, xm});
    chk("R6", "mdio_o",   {31'b0, mdio_o}, {31'b0, xo});
    chk("R7", "mdio_oe",  {31'b0, mdio_oe},{31'b0, xe});
    chk("R2", "man_rdata", man_rdata, m_reg);
    mdio_i = (m_busy && b >= 48) ? phy_val[63 - b] : 1'b1;
  end

  // ---------------- stimulus ----------------
  task automatic ctl(input bit en, input logic [1:0] dv);
    @(negedge clk); ctl_wr = 1; ctl_en = en; ctl_div = dv;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic man(input logic [31:0] w);
    @(negedge clk); man_wr = 1; man_wdata = w;
    @(negedge clk); man_wr = 0;
  endtask

  task automatic wait_done();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  initial begin
    logic [31:0] w;
    rst_n = 0; ctl_wr = 0; ctl_en = 0; ctl_div = 0; man_wr = 0; man_wdata = 0; mdio_i = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "reset idle",   {31'b0, idle},    32'd1);
    chk("R1", "reset mdc",    {31'b0, mdc},     32'd0);
    chk("R1", "reset oe",     {31'b0, mdio_oe}, 32'd0);
    chk("R1", "reset mdio_o", {31'b0, mdio_o},  32'd1);
    chk("R1", "reset rdata",  man_rdata,        32'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R3: enable off -> stored, no transfer (reset default disabled)
    w = mk(2'b10, 5'd3, 5'd1, 16'h0);
    man(w);
    chk("R3", "disabled no start", {31'b0, idle}, 32'd1);
    chk("R2", "stored word", man_rdata, w);

    // R8: read at /8
    ctl(1, 2'd0);
    phy_val = 16'hA5C3;
    w = mk(2'b10, 5'd3, 5'd2, 16'hFFFF);
    man(w);
    chk("R4", "busy after start", {31'b0, idle}, 32'd0);
    wait_done();
    chk("R8", "read capture", man_rdata, {w[31:16], 16'hA5C3});

    // R11: write at /16
    ctl(1, 2'd1);
    w = mk(2'b01, 5'd7, 5'd4, 16'h1234);
    man(w);
    // R9: mid-frame write ignored
    repeat (40) @(negedge clk);
    man(mk(2'b10, 5'd1, 5'd1, 16'h0));
    chk("R9", "mid write dropped", man_rdata, w);
    wait_done();
    chk("R11", "write keeps word", man_rdata, w);

    // R3: invalid words
    man({2'b11, 2'b01, 10'd5, 2'b10, 16'h1});
    chk("R3", "bad sof", {31'b0, idle}, 32'd1);
    man({2'b01, 2'b01, 10'd5, 2'b01, 16'h2});
    chk("R3", "bad code", {31'b0, idle}, 32'd1);
    man({2'b01, 2'b00, 10'd5, 2'b10, 16'h3});
    chk("R3", "bad op", {31'b0, idle}, 32'd1);

    // R9: write on the completion edge, then accepted one cycle later
    ctl(1, 2'd0);
    phy_val = 16'h5A0F;
    w = mk(2'b10, 5'd9, 5'd6, 16'h0);
    man(w);
    while (k != m_ts + 64 * m_N - 1) @(negedge clk);
    man_wr = 1; man_wdata = mk(2'b01, 5'd1, 5'd1, 16'hBEEF);
    @(negedge clk);
    chk("R9", "edge write dropped", man_rdata, {w[31:16], 16'h5A0F});
    chk("R9", "idle after edge write", {31'b0, idle}, 32'd1);
    @(negedge clk); man_wr = 0;
    chk("R9", "next write accepted", {31'b0, idle}, 32'd0);
    wait_done();

    // R10: /32 read, control changed mid-frame
    ctl(1, 2'd2);
    phy_val = 16'h0F1E;
    w = mk(2'b10, 5'd2, 5'd3, 16'h0);
    man(w);
    repeat (100) @(negedge clk);
    ctl(0, 2'd0);
    wait_done();
    chk("R10", "read done despite ctl write", man_rdata, {w[31:16], 16'h0F1E});
    man(mk(2'b01, 5'd2, 5'd3, 16'h1));
    chk("R3", "now disabled", {31'b0, idle}, 32'd1);

    // R5: /64 read
    ctl(1, 2'd3);
    phy_val = 16'hC001;
    w = mk(2'b10, 5'd31, 5'd31, 16'h0);
    man(w);
    wait_done();
    chk("R5", "div64 read", man_rdata, {w[31:16], 16'hC001});

    repeat (5) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule